// File: doc/BRIEF.md
# Streaming Checksum Generator and Verifier

The block keeps a running checksum over a stream of fixed-width data words. On every rising clock edge with reset released it folds the word on its data input into the checksum. Once a run of words has gone by, the value on the checksum output is the checksum of that run.

The same logic checks a received run. The sender's checksum is appended as one extra word after the same data words. The output then lands on exactly zero, and a zero flag that follows the output reports the match.

Internally the register holds the bitwise complement of a modulo-2^W running sum. That value starts at all ones, and each word is subtracted from it modulo 2^W. Adding a value to its own complement gives all ones, so appending the emitted checksum clears the output. Framing, counting words, storing checksums and reporting errors are left to the surrounding logic.

Top module: `csum_stream`

## Requirements
- R1: The data word width is the parameter WIDTH (default 8). The checksum output has the same width, so a WIDTH=13 instance resets to 13'h1FFF.
- R2: While rst_n is low, csum_o reads all ones (8'hFF at the default width).
- R3: zero_o is 1 exactly when csum_o is zero and 0 otherwise, on every cycle, including during reset.
- R4: Each rising clock edge with rst_n high folds exactly one data word: the new csum_o equals the old csum_o minus data_i, modulo 2^WIDTH.
- R5: From reset, feed a run of words and record csum_o. Then, from a fresh reset, feed the same run followed by the recorded value. This leaves csum_o at zero with zero_o high.
- R6: If one bit of one word in the repeated run is inverted, the output after the appended checksum is non-zero and zero_o is low.
- R7: The arithmetic wraps modulo 2^WIDTH, so runs of 512 words or more and long runs of 8'hFF keep properties R4 to R6.
- R8: Reset is asynchronous. Driving rst_n low between clock edges forces csum_o to all ones before the next edge, and accumulation restarts from all ones after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one word is folded per rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| data_i | input | WIDTH | Data word to fold into the checksum |
| csum_o | output | WIDTH | Complemented running sum (the checksum) |
| zero_o | output | 1 | High when csum_o is zero |

## Verification
On every cycle the assertions check four things: the all-ones value during reset, agreement between the zero flag and the output, the subtract-per-edge update rule, and the effect of a word that matches the current output (zero next) or differs from it (non-zero next). Some behaviours can only be shown by the bench's scenarios. These are the generate-then-verify round trip over 512-word random runs, detection of a single inverted bit anywhere in a run, wrap-around over long runs of all-ones words, the reset value of a wider instance, and the output clearing immediately when reset is driven low between edges.

// File: rtl/csum_pkg.sv
`timescale 1ns/1ps
package csum_pkg;

  localparam int unsigned CSUM_DEF_WIDTH = 8;

  typedef enum logic {
    SUB_BEHAV = 1'b0,
    SUB_RIPPLE = 1'b1
  } sub_style_e;

endpackage

// File: rtl/csum_sub.sv
`timescale 1ns/1ps
module csum_sub
  import csum_pkg::*;
#(
  parameter int unsigned WIDTH = CSUM_DEF_WIDTH,
  parameter sub_style_e STYLE = SUB_BEHAV
) (
  input  logic [WIDTH-1:0] min_i,
  input  logic [WIDTH-1:0] sub_i,
  output logic [WIDTH-1:0] diff_o
);

  generate
    if (STYLE == SUB_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] inv_sub;
      logic [WIDTH-1:0] cy;

      assign inv_sub = ~sub_i;
      assign cy[0]   = 1'b1;

      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign diff_o[i] = min_i[i] ^ inv_sub[i] ^ cy[i];
        if (i < WIDTH - 1) begin : g_carry
          assign cy[i+1] = (min_i[i] & inv_sub[i]) |
                           (min_i[i] & cy[i]) |
                           (inv_sub[i] & cy[i]);
        end
      end
    end else begin : g_behav
      assign diff_o = min_i - sub_i;
    end
  endgenerate

endmodule

// File: rtl/csum_zero_det.sv
`timescale 1ns/1ps
module csum_zero_det
  import csum_pkg::*;
#(
  parameter int unsigned WIDTH = CSUM_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             zero_o
);

  assign zero_o = ~(|word_i);

endmodule

// File: rtl/csum_stream.sv
`timescale 1ns/1ps
module csum_stream
  import csum_pkg::*;
#(
  parameter int unsigned WIDTH = CSUM_DEF_WIDTH,
  parameter sub_style_e STYLE = SUB_BEHAV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] csum_o,
  output logic             zero_o
);

  localparam logic [WIDTH-1:0] SEED = '1;

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] acc_d;
  logic [WIDTH-1:0] diff;

  // Complemented sum: ~(S + d) == ~S - d, so subtract in place.
  csum_sub #(
    .WIDTH (WIDTH),
    .STYLE (STYLE)
  ) u_sub (
    .min_i  (acc_q),
    .sub_i  (data_i),
    .diff_o (diff)
  );

  always_comb begin
    acc_d = diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= SEED;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign csum_o = acc_q;

  csum_zero_det #(
    .WIDTH (WIDTH)
  ) u_zero (
    .word_i (acc_q),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/csum_stream_chk.sv
`timescale 1ns/1ps
module csum_stream_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] csum_o,
  input logic             zero_o
);

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_ONES: assert (csum_o == {WIDTH{1'b1}}); // R2
    end
  end

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (csum_o == '0)); // R3

  AST_FOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> csum_o == $past(csum_o - data_i)); // R4

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_i == csum_o) |=> zero_o); // R5

  AST_MISMATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_i != csum_o) |=> !zero_o); // R6

endmodule

bind csum_stream csum_stream_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/csum_stream_test.sv
`timescale 1ns/1ps
module csum_stream_test;

  localparam int W = 8;
  localparam int WW = 13;
  localparam int RUN = 512;

  typedef struct {
    logic [W-1:0] v;
    logic         z;
    string        rq;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  data;
  logic [W-1:0]  csum;
  logic          zero;
  logic [WW-1:0] data_w;
  logic [WW-1:0] csum_w;
  logic          zero_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model;
  exp_t q[$];

  always #10 clk = ~clk; // 50 MHz

  csum_stream #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .data_i(data), .csum_o(csum), .zero_o(zero)
  );

  csum_stream #(.WIDTH(WW), .STYLE(csum_pkg::SUB_RIPPLE)) uut_wide (
    .clk(clk), .rst_n(rst_n), .data_i(data_w), .csum_o(csum_w), .zero_o(zero_w)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic push_exp(string rq);
    exp_t e;
    e.v = model;
    e.z = (model == '0);
    e.rq = rq;
    q.push_back(e);
  endtask

  task automatic send(logic [W-1:0] w, string rq);
    @(negedge clk);
    data = w;
    model = model - w;
    push_exp(rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2 chk("R8 async clear", 32'(csum), 32'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    data = '0;
    model = '1;
    push_exp("R8 restart");
  endtask

  task automatic read_out(output logic [W-1:0] v);
    @(posedge clk);
    #6 v = csum;
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.rq, " csum"}, 32'(csum), 32'(e.v));
        chk({e.rq, " zero R3"}, 32'(zero), 32'(e.z));
      end
    end
  end

  initial begin
    logic [W-1:0] words [RUN];
    logic [W-1:0] rec;
    logic [W-1:0] fin;
    rst_n = 1'b0;
    data = '0;
    data_w = '0;
    model = '1;
    repeat (2) @(negedge clk);
    chk("R2 reset ones", 32'(csum), 32'hFF);
    chk("R3 zero low in reset", 32'(zero), 32'h0);
    chk("R1 wide reset ones", 32'(csum_w), 32'h1FFF);
    @(negedge clk);
    rst_n = 1'b1;
    push_exp("R2 release");

    // R1: wider instance round trip
    @(negedge clk) data_w = 13'h1234;
    @(posedge clk) #6 chk("R1 wide step", 32'(csum_w), 32'h0DCB);
    @(negedge clk) data_w = 13'h0DCB;
    @(posedge clk) #6 chk("R1 wide zero", 32'(csum_w), 32'h0);
    chk("R1 wide flag", 32'(zero_w), 32'h1);
    @(negedge clk) data_w = '0;

    // R4: single-word patterns
    send(8'h00, "R4 zero word");
    send(8'h01, "R4 one");
    send(8'hFF, "R4 ff");
    send(8'h80, "R4 msb");
    send(8'h5A, "R4 mix");
    send(model, "R3 hit zero");
    send(8'h01, "R4 below zero");

    // R7: wrap over long run of ones
    for (int i = 0; i < 600; i++) send(8'hFF, "R7 wrap");
    do_reset();

    // R5 / R6: generate then verify
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < RUN; i++) words[i] = W'($urandom_range(255, 0));
      do_reset();
      for (int i = 0; i < RUN; i++) send(words[i], "R4 gen run");
      read_out(rec);
      chk("R7 run sum", 32'(rec), 32'(model));
      do_reset();
      for (int i = 0; i < RUN; i++) begin
        if ((t % 2) == 1 && i == (t * 83) % RUN)
          send(words[i] ^ W'(1 << (t % W)), "R6 corrupt run");
        else
          send(words[i], "R5 replay");
      end
      send(rec, "R5 append");
      read_out(fin);
      if ((t % 2) == 1) begin
        chk("R6 nonzero", 32'(fin != '0), 32'h1);
        chk("R6 flag low", 32'(zero), 32'h0);
      end else begin
        chk("R5 zero out", 32'(fin), 32'h0);
        chk("R5 flag high", 32'(zero), 32'h1);
      end
    end
    do_reset();
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule